// File: doc/BRIEF.md
# ATA Programmed-I/O Cycle Timing Engine

This block runs a single programmed-I/O read or write on an ATA device bus. A request brings a 4-bit register address, a direction and a 16-bit write word. The engine then steps through four timed phases. In the first, the address and chip select are set up. In the second, the read or write strobe is held low. In the third, the address, and on a write the data as well, are held after the strobe rises. The fourth is recovery. Each phase lasts a programmable number of clocks.

The engine acknowledges the transfer when the strobe rises, and on a read it returns the word it sampled at that edge. Three timing words are supplied from outside: one for command-block accesses and one for each of the two devices' data-port accesses. Each comes with its own enable for device wait-state stretching. The timing word and the enable are captured when a request is accepted. At a 100 MHz clock, mode-0 values of 6/28/2/23 give a cycle of about 600 ns.

Top module: `ata_pio_engine`

## Requirements
- R1: While reset is asserted and after it is released with no request, busy_o, ack_o and dd_oe_o are 0, and cs0_no, cs1_no, dior_no and diow_no are 1.
- R2: From acceptance until the hold phase ends, exactly one chip select is low: cs1_no when addr bit 3 is 1, otherwise cs0_no. da_o equals addr bits 2:0.
- R3: The setup phase lasts max(t1,1) clocks: chip select is low with no strobe for that many cycles before the strobe falls.
- R4: With wait-state stretching inactive, the strobe stays low for max(t2,1) clocks. A read drives only dior_no low and a write drives only diow_no low.
- R5: After the strobe rises, chip select and address stay valid for max(t4,1) clocks.
- R6: After the hold phase, busy_o stays high with chip select released for max(teoc,1) clocks, then drops.
- R7: ack_o is high for exactly one clock, the first clock after the strobe rises. On a read, rdata_o then holds the dd_i value present at the clock edge that ended the strobe.
- R8: A timing word packs t1 in bits 7:0, t2 in 15:8, t4 in 23:16 and teoc in 31:24. Address 4'b0000 (the data port) uses tim_dev1_i when dev_i is 1 and tim_dev0_i when dev_i is 0. Every other address uses tim_cmd_i. The wait enable comes from iordy_en_i bit 0 (command), bit 1 (device 0) or bit 2 (device 1).
- R9: iordy_i passes through a two-flop synchroniser. When the selected set's wait enable is 1 and the synchronised iordy_i is low when the strobe count expires, the strobe stays low until it reads high. Raising iordy_i at a point when the strobe has already been low for L ≥ max(t2,1) clocks gives a strobe width of L+2. With the enable at 0, iordy_i has no effect.
- R10: A request, or a change in address or direction, presented while busy_o is high has no effect on the running cycle.
- R11: dd_oe_o is 1 only during a write, from acceptance through the hold phase, and dd_o then equals the accepted write word.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a cycle; accepted when idle |
| addr_i | input | 4 | Bit 3 chip-select choice, bits 2:0 device address |
| we_i | input | 1 | 1 write, 0 read |
| wdata_i | input | 16 | Write word |
| dev_i | input | 1 | Device targeted by data-port accesses |
| tim_cmd_i | input | 32 | Command-block timing word |
| tim_dev0_i | input | 32 | Device 0 data-port timing word |
| tim_dev1_i | input | 32 | Device 1 data-port timing word |
| iordy_en_i | input | 3 | Wait enables per timing set |
| busy_o | output | 1 | Cycle in progress |
| ack_o | output | 1 | One-clock transfer acknowledge |
| rdata_o | output | 16 | Captured read word |
| da_o | output | 3 | Device address lines |
| cs0_no | output | 1 | Command-block chip select, active low |
| cs1_no | output | 1 | Control-block chip select, active low |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| dd_i | input | 16 | Device data bus in |
| dd_o | output | 16 | Device data bus out |
| dd_oe_o | output | 1 | Data bus output enable |
| iordy_i | input | 1 | Device ready, asynchronous |

## Verification
The hardest condition to reach is a strobe stretched by the ready line. It needs the selected timing set's wait enable, iordy_i already low when the strobe count runs out, and a release that lands at a known point so that the two-flop latency shows in the width. The bench holds iordy_i low from the start of such cycles. It counts strobe-low clocks and raises iordy_i three clocks after the programmed width, so it expects that width plus five. Random cycles over all three timing sets, including zero-valued phases and the mode-0 defaults, cover the selection logic and the minimum-length phases.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int TW = 8;

  typedef struct packed {
    logic [TW-1:0] teoc;
    logic [TW-1:0] t4;
    logic [TW-1:0] t2;
    logic [TW-1:0] t1;
  } pio_tim_t;

  localparam int TIM_W = $bits(pio_tim_t);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD,
    PH_RECOV
  } pio_phase_e;

  // zero is treated as a one-clock phase
  function automatic logic [TW-1:0] ph_load(input logic [TW-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction
endpackage

// File: rtl/ata_iordy_sync.sv
module ata_iordy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ata_pio_tsel.sv
module ata_pio_tsel
  import ata_pio_pkg::*;
#(
  parameter int AW     = 4,
  parameter int N_SETS = 3
) (
  input  logic [AW-1:0]         addr_i,
  input  logic                  dev_i,
  input  logic [N_SETS*TIM_W-1:0] tim_i,
  input  logic [N_SETS-1:0]     ior_en_i,
  output pio_tim_t              tim_o,
  output logic                  ior_en_o
);
  localparam int SW = $clog2(N_SETS);

  logic [SW-1:0] idx;
  pio_tim_t      set_tim [N_SETS];

  for (genvar g = 0; g < N_SETS; g++) begin : g_set
    assign set_tim[g] = pio_tim_t'(tim_i[g*TIM_W +: TIM_W]);
  end

  // data port: cs0 with address 0; set 1/2 by device
  always_comb begin
    idx = '0;
    if (addr_i == '0) idx = dev_i ? SW'(2) : SW'(1);
  end

  assign tim_o    = set_tim[idx];
  assign ior_en_o = ior_en_i[idx];
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  pio_tim_t      tim_i,
  input  logic          ior_en_i,
  input  logic          iordy_s_i,
  input  logic [DW-1:0] dd_i,
  output logic          busy_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [2:0]    da_o,
  output logic          cs0_no,
  output logic          cs1_no,
  output logic          dior_no,
  output logic          diow_no,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe_o
);
  pio_phase_e    ph_q;
  logic [TW-1:0] cnt_q;
  pio_tim_t      tim_q;
  logic          ior_en_q, we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          cs_act;
  logic          cnt_done;

  assign cnt_done = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      tim_q    <= '0;
      ior_en_q <= 1'b0;
      we_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_o  <= '0;
      ack_o    <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      unique case (ph_q)
        PH_IDLE: if (req_i) begin
          addr_q   <= addr_i;
          we_q     <= we_i;
          wdata_q  <= wdata_i;
          tim_q    <= tim_i;
          ior_en_q <= ior_en_i;
          cnt_q    <= ph_load(tim_i.t1);
          ph_q     <= PH_SETUP;
        end
        PH_SETUP:
          if (cnt_done) begin
            cnt_q <= ph_load(tim_q.t2);
            ph_q  <= PH_STROBE;
          end else cnt_q <= cnt_q - 1'b1;
        PH_STROBE:
          if (!cnt_done) cnt_q <= cnt_q - 1'b1;
          else if (!(ior_en_q && !iordy_s_i)) begin
            cnt_q <= ph_load(tim_q.t4);
            ph_q  <= PH_HOLD;
            ack_o <= 1'b1;
            if (!we_q) rdata_o <= dd_i;
          end
        PH_HOLD:
          if (cnt_done) begin
            cnt_q <= ph_load(tim_q.teoc);
            ph_q  <= PH_RECOV;
          end else cnt_q <= cnt_q - 1'b1;
        PH_RECOV:
          if (cnt_done) ph_q <= PH_IDLE;
          else          cnt_q <= cnt_q - 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o  = (ph_q != PH_IDLE);
  assign cs_act  = (ph_q == PH_SETUP) || (ph_q == PH_STROBE) || (ph_q == PH_HOLD);
  assign cs0_no  = !(cs_act && !addr_q[AW-1]);
  assign cs1_no  = !(cs_act && addr_q[AW-1]);
  assign da_o    = addr_q[2:0];
  assign dior_no = !((ph_q == PH_STROBE) && !we_q);
  assign diow_no = !((ph_q == PH_STROBE) && we_q);
  assign dd_oe_o = cs_act && we_q;
  assign dd_o    = wdata_q;

  p_one_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_no && !diow_no));
  p_strobe_has_cs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dior_no || !diow_no) |-> (cs0_no != cs1_no));
  p_no_oe_on_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dior_no |-> !dd_oe_o);
  p_ack_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_ack_after_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(ph_q == PH_STROBE));
  p_addr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(addr_q));
  p_wait_state_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_STROBE && cnt_done && ior_en_q && !iordy_s_i) |=> (ph_q == PH_STROBE));
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 16,
  parameter int SYNC_ST = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          dev_i,
  input  logic [31:0]   tim_cmd_i,
  input  logic [31:0]   tim_dev0_i,
  input  logic [31:0]   tim_dev1_i,
  input  logic [2:0]    iordy_en_i,
  output logic          busy_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic [2:0]    da_o,
  output logic          cs0_no,
  output logic          cs1_no,
  output logic          dior_no,
  output logic          diow_no,
  input  logic [DW-1:0] dd_i,
  output logic [DW-1:0] dd_o,
  output logic          dd_oe_o,
  input  logic          iordy_i
);
  pio_tim_t sel_tim;
  logic     sel_ior_en;
  logic     iordy_s;

  ata_iordy_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (iordy_i),
    .q_o   (iordy_s)
  );

  ata_pio_tsel #(.AW(AW), .N_SETS(3)) u_tsel (
    .addr_i  (addr_i),
    .dev_i   (dev_i),
    .tim_i   ({tim_dev1_i, tim_dev0_i, tim_cmd_i}),
    .ior_en_i(iordy_en_i),
    .tim_o   (sel_tim),
    .ior_en_o(sel_ior_en)
  );

  ata_pio_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .tim_i    (sel_tim),
    .ior_en_i (sel_ior_en),
    .iordy_s_i(iordy_s),
    .dd_i     (dd_i),
    .busy_o   (busy_o),
    .ack_o    (ack_o),
    .rdata_o  (rdata_o),
    .da_o     (da_o),
    .cs0_no   (cs0_no),
    .cs1_no   (cs1_no),
    .dior_no  (dior_no),
    .diow_no  (diow_no),
    .dd_o     (dd_o),
    .dd_oe_o  (dd_oe_o)
  );
endmodule

// File: tb/ata_pio_engine_tb_top.sv
module ata_pio_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        dev_i = 1'b0;
  logic [31:0] tim_cmd_i, tim_dev0_i, tim_dev1_i;
  logic [2:0]  iordy_en_i = '0;
  logic        busy_o, ack_o;
  logic [15:0] rdata_o;
  logic [2:0]  da_o;
  logic        cs0_no, cs1_no, dior_no, diow_no;
  logic [15:0] dd_i = '0;
  logic [15:0] dd_o;
  logic        dd_oe_o;
  logic        iordy_i = 1'b1;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ata_pio_engine dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .dev_i(dev_i), .tim_cmd_i(tim_cmd_i), .tim_dev0_i(tim_dev0_i),
    .tim_dev1_i(tim_dev1_i), .iordy_en_i(iordy_en_i), .busy_o(busy_o), .ack_o(ack_o),
    .rdata_o(rdata_o), .da_o(da_o), .cs0_no(cs0_no), .cs1_no(cs1_no), .dior_no(dior_no),
    .diow_no(diow_no), .dd_i(dd_i), .dd_o(dd_o), .dd_oe_o(dd_oe_o), .iordy_i(iordy_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mx(input logic [7:0] t);
    return (t == 0) ? 1 : int'(t);
  endfunction

  function automatic logic [31:0] pack_t(input int a, input int b, input int c, input int d);
    return {d[7:0], c[7:0], b[7:0], a[7:0]};
  endfunction

  // R8: set index from address and device
  function automatic int set_of(input logic [3:0] a, input logic d);
    if (a != 4'b0000) return 0;
    return d ? 2 : 1;
  endfunction

  task automatic run_cycle(input logic [3:0] a, input logic w, input logic [15:0] wd,
                           input logic d, input logic [15:0] rd, input bit hold_rdy,
                           input bit keep_req);
    int s;
    logic [31:0] tw;
    int e1, e2, e4, ee, lim;
    bit ext;
    int c1, c2, c4, ce, acks;
    bit seen, ack_ok, bad_da, bad_cs, bad_strb, bad_oe;
    bit cs_act, strb;
    s   = set_of(a, d);
    tw  = (s == 0) ? tim_cmd_i : (s == 1) ? tim_dev0_i : tim_dev1_i;
    e1  = mx(tw[7:0]);
    e4  = mx(tw[23:16]);
    ee  = mx(tw[31:24]);
    ext = iordy_en_i[s] && hold_rdy;
    lim = mx(tw[15:8]) + 3;
    e2  = ext ? lim + 2 : mx(tw[15:8]);
    c1 = 0; c2 = 0; c4 = 0; ce = 0; acks = 0;
    seen = 0; ack_ok = 0; bad_da = 0; bad_cs = 0; bad_strb = 0; bad_oe = 0;
    @(negedge clk);
    addr_i = a; we_i = w; wdata_i = wd; dev_i = d; dd_i = rd;
    iordy_i = !hold_rdy; req_i = 1'b1;
    @(posedge clk);
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (!busy_o) break;
      if (keep_req) begin
        addr_i = ~a; we_i = ~w;
      end else req_i = 1'b0;
      acks += int'(ack_o);
      cs_act = !cs0_no || !cs1_no;
      strb   = !dior_no || !diow_no;
      if (cs_act && da_o != a[2:0]) bad_da = 1;
      if (cs_act && (cs0_no != a[3] || cs1_no != !a[3])) bad_cs = 1;
      if (strb) begin
        if (w ? (!dior_no || diow_no) : (!diow_no || dior_no)) bad_strb = 1;
        c2++;
        seen = 1;
        if (ext && c2 == lim) iordy_i = 1'b1;
      end else if (cs_act) begin
        if (seen) begin
          if (c4 == 0 && ack_o) ack_ok = 1;
          c4++;
        end else c1++;
      end else ce++;
      if (dd_oe_o != (cs_act && w)) bad_oe = 1;
      if (dd_oe_o && dd_o != wd) bad_oe = 1;
    end
    req_i = 1'b0;
    iordy_i = 1'b1;
    chk(c1 == e1, "R3 setup length", c1, e1);
    chk(c2 == e2, ext ? "R9 stretched strobe" : "R4 strobe width", c2, e2);
    chk(c4 == e4, "R5 hold length", c4, e4);
    chk(ce == ee, "R6 recovery length", ce, ee);
    chk(!bad_cs && !bad_da, "R2 chip select and address", int'(bad_cs), 0);
    chk(!bad_strb, "R4 strobe direction", int'(bad_strb), 0);
    chk(!bad_oe, "R11 output enable and data", int'(bad_oe), 0);
    chk(ack_ok && acks == 1, "R7 ack pulse", acks, 1);
    if (!w) chk(rdata_o == rd, "R7 read capture", int'(rdata_o), int'(rd));
    if (keep_req) chk(c1 == e1 && ce == ee, "R10 busy ignores request", c1 + ce, e1 + ee);
  endtask

  initial begin
    #4000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tim_cmd_i  = pack_t(6, 28, 2, 23);
    tim_dev0_i = pack_t(3, 5, 1, 4);
    tim_dev1_i = pack_t(0, 0, 0, 0);
    #35;
    // R1: reset state
    chk(!busy_o && !ack_o && !dd_oe_o, "R1 reset idle", int'(busy_o), 0);
    chk(cs0_no && cs1_no && dior_no && diow_no, "R1 reset strobes",
        int'({cs0_no, cs1_no, dior_no, diow_no}), 15);
    @(negedge clk) rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && cs0_no && cs1_no && dior_no && diow_no, "R1 idle after reset",
        int'(busy_o), 0);

    // directed: default timing, command port read and write
    run_cycle(4'b0111, 1'b0, 16'h0000, 1'b0, 16'hA5C3, 0, 0);
    run_cycle(4'b1110, 1'b1, 16'h1234, 1'b0, 16'h0000, 0, 0);
    // R8: data port per device, zero timings on device 1
    run_cycle(4'b0000, 1'b1, 16'hBEEF, 1'b0, 16'h0, 0, 0);
    run_cycle(4'b0000, 1'b0, 16'h0, 1'b1, 16'h5AA5, 0, 0);
    // R9: iordy disabled -> no effect
    run_cycle(4'b0001, 1'b0, 16'h0, 1'b0, 16'h0F0F, 1, 0);
    // R9: iordy enabled on device 0 set
    iordy_en_i = 3'b010;
    run_cycle(4'b0000, 1'b0, 16'h0, 1'b0, 16'hC001, 1, 0);
    run_cycle(4'b0000, 1'b1, 16'h7777, 1'b0, 16'h0, 1, 0);
    // enabled but other set selected -> ignored
    run_cycle(4'b0000, 1'b0, 16'h0, 1'b1, 16'h1111, 1, 0);
    // R10: request held and address toggled while busy
    run_cycle(4'b1010, 1'b1, 16'h4321, 1'b0, 16'h0, 0, 1);

    // random cycles
    for (int i = 0; i < 40; i++) begin
      logic [3:0] a;
      tim_cmd_i  = pack_t($urandom % 9, $urandom % 9, $urandom % 4, $urandom % 9);
      tim_dev0_i = pack_t($urandom % 9, $urandom % 9, $urandom % 4, $urandom % 9);
      tim_dev1_i = pack_t($urandom % 9, $urandom % 9, $urandom % 4, $urandom % 9);
      iordy_en_i = 3'($urandom);
      a = ($urandom % 3 == 0) ? 4'b0000 : 4'($urandom);
      run_cycle(a, 1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom),
                ($urandom % 4) == 0, ($urandom % 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule